// File: doc/BRIEF.md
# Weighted Round-Robin Access Arbiter

This block shares one resource among four requesters, such as bus masters or the input ports of a switch. Each requester raises a request bit and receives a registered one-hot grant. The grant stays in place for a whole access, which may last many cycles. It ends only when the holder raises its own bit of the end-of-access vector.

Every requester has a programmable weight. The arbiter keeps a credit count for each requester. A completed access costs one credit, and a requester whose credit is used up is passed over while others still have credit. When no requester that is asking has any credit left, a new round begins and every credit is refilled from the weights. Within a round the search for the next holder starts just past the previous holder and wraps around. Heavier requesters therefore get more accesses per round, and no steady requester waits forever. The weights are assumed constant while a round is in progress.

Top module: `wrr_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the grant clears to all zeros, the search start position becomes requester 0, and every credit is loaded from its weight.
- R2: The grant output is registered and never has more than one bit set. When no grant is held and any request is high at a clock edge, the grant selects a requesting agent from the next cycle on.
- R3: A held grant does not change until the end-of-access bit at the granted position is high. End-of-access bits at other positions, or any end-of-access while no grant is held, have no effect.
- R4: When the current access ends and at least one request is high, the next grant appears in the following cycle with no idle cycle in between.
- R5: When the current access ends and no request is high, the grant clears to zero in the following cycle.
- R6: The search for a new holder begins at the position one above the last granted requester, wrapping from 3 to 0. The first search after reset begins at requester 0.
- R7: Each completed access takes one credit from the requester that held the grant. A requester with zero credit is skipped while some requesting agent still has credit.
- R8: When a grant decision finds that no requesting agent has credit, all credits are reloaded from the weights in that same cycle, and the choice is made among all requesting agents.
- R9: A weight of 0 acts as a weight of 1. With weights (3,1,2,0) for requesters 0..3, all requesting, and every access lasting one cycle, the grants after reset go 0,1,2,3,0,2,0 for the first round and then 1.
- R10: A requester that keeps its request high is granted before more than 3*(2^WW-1)+4 other accesses complete, where WW is the weight width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NREQ | One request bit per requester |
| end_i | input | NREQ | End-of-access bits; only the bit of the current holder counts |
| weight_i | input | NREQ*WW | Packed weights, requester i at bits [i*WW +: WW] |
| gnt_o | output | NREQ | Registered one-hot grant, all zero when idle |

## Verification
A completed access and the start of a new round can land in the same cycle. The holder's credit is spent, and the decision then sees that no requesting agent has credit, so the reload replaces the decrement while the next holder is chosen. The directed sequence with weights (3,1,2,0) reaches this on its eighth grant. A sweep over sixteen weight sets with pseudo-random request and end-of-access patterns reaches it many more times. In every cycle the grant is compared with an arithmetic credit model kept in the bench.

// File: rtl/wrr_pkg.sv
// Package: shared types for the weighted round-robin arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package wrr_pkg;

    // Control state: no grant held, or one access in progress.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } arb_state_t;

endpackage

// File: rtl/wrr_credit_bank.sv
// Module: wrr_credit_bank
// Holds one credit counter per requester. A one-hot completion vector
// spends one credit, and a reload refills every counter from its weight.
// A weight of zero counts as one. has_credit_o shows the credits as they
// stand after this cycle's completion, so a decision made in the same
// cycle sees the spent credit.
// Assumes: done_i has at most one bit set, and that bit belongs to a
// requester with nonzero credit.
module wrr_credit_bank #(
    parameter int NREQ = 4,
    parameter int WW   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREQ*WW-1:0]  weight_i,
    input  logic [NREQ-1:0]     done_i,
    input  logic                reload_i,
    output logic [NREQ-1:0]     has_credit_o
);

    localparam logic [WW-1:0] ONE = WW'(1);

    for (genvar g = 0; g < NREQ; g++) begin : g_cred
        logic [WW-1:0] wgt;
        logic [WW-1:0] eff;
        logic [WW-1:0] cred_q;
        logic [WW-1:0] cred_after;

        // Slice this requester's weight and map zero to one.
        always_comb begin
            wgt = weight_i[g*WW +: WW];
            eff = (wgt == '0) ? ONE : wgt;
        end

        // Apply this cycle's completion to the stored credit.
        always_comb begin
            cred_after = done_i[g] ? (cred_q - ONE) : cred_q;
        end

        assign has_credit_o[g] = (cred_after != '0);

        // Credit register: load on reset or reload, otherwise keep the spent value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cred_q <= eff;
            end else if (reload_i) begin
                cred_q <= eff;
            end else begin
                cred_q <= cred_after;
            end
        end
    end

endmodule

// File: rtl/wrr_rr_pick.sv
// Module: wrr_rr_pick
// Rotating first-one finder. Starting at start_i and wrapping, it picks
// the first set bit of elig_i and returns it as a one-hot vector and an
// index. found_o is low when elig_i is empty.
// Assumes: start_i < NREQ.
module wrr_rr_pick #(
    parameter int NREQ = 4,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] elig_i,
    input  logic [IW-1:0]   start_i,
    output logic [NREQ-1:0] pick_oh_o,
    output logic [IW-1:0]   pick_idx_o,
    output logic            found_o
);

    // Walk the positions from start_i upward with wrap; keep the first hit.
    always_comb begin
        logic [IW:0] pos;
        pick_oh_o  = '0;
        pick_idx_o = '0;
        found_o    = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            pos = {1'b0, start_i} + (IW+1)'(k);
            if (pos >= (IW+1)'(NREQ)) begin
                pos = pos - (IW+1)'(NREQ);
            end
            if (!found_o && elig_i[pos[IW-1:0]]) begin
                found_o                 = 1'b1;
                pick_idx_o              = pos[IW-1:0];
                pick_oh_o[pos[IW-1:0]]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrr_arbiter.sv
// Module: wrr_arbiter (top)
// Weighted round-robin arbiter with held grants. A grant lasts until
// its holder raises end-of-access. A decision is made when the block
// is idle with requests pending, or when the current access ends. Only
// requesters that still have credit take part, unless none of those
// asking has any, in which case a new round reloads every credit.
// Assumes: weights stay constant within a round; the reset is synchronous
// and active low.
module wrr_arbiter #(
    parameter int NREQ = 4,
    parameter int WW   = 3,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREQ-1:0]     req_i,
    input  logic [NREQ-1:0]     end_i,
    input  logic [NREQ*WW-1:0]  weight_i,
    output logic [NREQ-1:0]     gnt_o
);
    import wrr_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(NREQ - 1);

    arb_state_t      state_q, state_d;
    logic [NREQ-1:0] gnt_q, gnt_d;
    logic [IW-1:0]   ptr_q, ptr_d;

    logic            any_req;
    logic            end_hit;
    logic            decide;
    logic            new_round;
    logic [NREQ-1:0] done_vec;
    logic [NREQ-1:0] has_credit;
    logic [NREQ-1:0] elig_raw;
    logic [NREQ-1:0] pick_in;
    logic [NREQ-1:0] pick_oh;
    logic [IW-1:0]   pick_idx;
    logic            pick_found;

    // Decode completion and the decision event.
    always_comb begin
        any_req  = |req_i;
        end_hit  = (state_q == ST_ACCESS) && |(end_i & gnt_q);
        decide   = ((state_q == ST_IDLE) && any_req) || end_hit;
        done_vec = end_hit ? gnt_q : '0;
    end

    wrr_credit_bank #(
        .NREQ (NREQ),
        .WW   (WW)
    ) u_credit (
        .clk          (clk),
        .rst_n        (rst_n),
        .weight_i     (weight_i),
        .done_i       (done_vec),
        .reload_i     (new_round),
        .has_credit_o (has_credit)
    );

    // Eligibility; start a new round when no requester asking has credit.
    always_comb begin
        elig_raw  = req_i & has_credit;
        new_round = decide && any_req && (elig_raw == '0);
        pick_in   = new_round ? req_i : elig_raw;
    end

    wrr_rr_pick #(
        .NREQ (NREQ)
    ) u_pick (
        .elig_i     (pick_in),
        .start_i    (ptr_q),
        .pick_oh_o  (pick_oh),
        .pick_idx_o (pick_idx),
        .found_o    (pick_found)
    );

    // Next state, next grant and next search start.
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        ptr_d   = ptr_q;
        if (decide) begin
            if (any_req && pick_found) begin
                state_d = ST_ACCESS;
                gnt_d   = pick_oh;
                ptr_d   = (pick_idx == LAST) ? '0 : (pick_idx + IW'(1));
            end else begin
                state_d = ST_IDLE;
                gnt_d   = '0;
            end
        end
    end

    // Control registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
            ptr_q   <= ptr_d;
        end
    end

    assign gnt_o = gnt_q;

endmodule

// File: rtl/wrr_arbiter_chk.sv
// Module: wrr_arbiter_chk
// Property checker for wrr_arbiter, attached through bind. It watches
// only the ports and keeps a wait counter per requester for the
// starvation bound.
// Assumes: the same parameters as the arbiter it is bound to.
module wrr_arbiter_chk #(
    parameter int NREQ = 4,
    parameter int WW   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NREQ-1:0]     req_i,
    input logic [NREQ-1:0]     end_i,
    input logic [NREQ-1:0]     gnt_o
);

    localparam int WMAX       = (1 << WW) - 1;
    localparam int STARVE_MAX = (NREQ - 1) * WMAX + NREQ;
    localparam int CW         = $clog2(STARVE_MAX + 2) + 1;

    logic end_hit;
    assign end_hit = (gnt_o != '0) && ((end_i & gnt_o) != '0);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2

    AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0)); // R2

    AST_NEW_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !$stable(gnt_o)) |-> ((gnt_o & $past(req_i)) != '0)); // R2

    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !end_hit) |=> $stable(gnt_o)); // R3

    AST_END_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && req_i != '0) |=> (gnt_o != '0)); // R4

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && req_i == '0) |=> (gnt_o == '0)); // R5

    for (genvar g = 0; g < NREQ; g++) begin : g_starve
        logic [CW-1:0] wait_q;

        // Count other accesses completed while requester g waits.
        always_ff @(posedge clk) begin
            if (!rst_n || !req_i[g] || gnt_o[g]) begin
                wait_q <= '0;
            end else if (end_hit && wait_q != '1) begin
                wait_q <= wait_q + CW'(1);
            end
        end

        AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q <= CW'(STARVE_MAX)); // R10
    end

endmodule

bind wrr_arbiter wrr_arbiter_chk #(
    .NREQ (NREQ),
    .WW   (WW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .end_i (end_i),
    .gnt_o (gnt_o)
);

// File: tb/tb_wrr_arbiter.sv
`timescale 1ns/1ps
// Bench for wrr_arbiter. Directed cases cover reset, hold, clear and the
// weighted sequence. A sweep over sixteen weight sets compares the grant
// in every cycle with an arithmetic credit model.
module tb_wrr_arbiter;
    localparam int N = 4;
    localparam int W = 3;
    localparam int STARVE_MAX = (N - 1) * ((1 << W) - 1) + N;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N-1:0]   endv = '0;
    logic [N*W-1:0] wts = '0;
    logic [N-1:0]   gnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state
    int mgnt;
    int mptr;
    int mcred [N];
    int waitc [N];
    int waitmax;
    logic [15:0] lfsr = 16'hACE1;

    wrr_arbiter #(.NREQ(N), .WW(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .end_i    (endv),
        .weight_i (wts),
        .gnt_o    (gnt)
    );

    always #4 clk = ~clk;

    // Effective weight of agent a
    function automatic int effw(int a);
        int v;
        v = int'(wts[a*W +: W]);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [N-1:0] exp_vec();
        logic [N-1:0] v;
        v = '0;
        if (mgnt >= 0) v[mgnt] = 1'b1;
        return v;
    endfunction

    task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp_max);
        checks++;
        if (act > exp_max) begin
            errors++;
            $display("FAIL %s: actual=%0d expected<=%0d", tag, act, exp_max);
        end
    endtask

    // One clock edge of the model
    task automatic model_step(logic [N-1:0] rq, logic [N-1:0] ev);
        bit hit, dec, any;
        int sel;
        int p;
        any = (rq != '0);
        hit = (mgnt >= 0) && ev[mgnt];
        if (hit) mcred[mgnt] = mcred[mgnt] - 1;
        dec = ((mgnt < 0) && any) || hit;
        if (!dec) return;
        if (!any) begin
            mgnt = -1;
            return;
        end
        sel = -1;
        for (int k = 0; k < N; k++) begin
            p = (mptr + k) % N;
            if (sel < 0 && rq[p] && mcred[p] > 0) sel = p;
        end
        if (sel < 0) begin
            for (int a = 0; a < N; a++) mcred[a] = effw(a);
            for (int k = 0; k < N; k++) begin
                p = (mptr + k) % N;
                if (sel < 0 && rq[p]) sel = p;
            end
        end
        mgnt = sel;
        mptr = (sel + 1) % N;
    endtask

    // Drive one cycle's inputs, advance the model, sample after the edge.
    task automatic cyc(logic [N-1:0] rq, logic [N-1:0] ev);
        bit hit;
        req  = rq;
        endv = ev;
        hit = (mgnt >= 0) && ev[mgnt];
        for (int a = 0; a < N; a++) begin
            if (!rq[a] || mgnt == a) waitc[a] = 0;
            else if (hit) waitc[a] = waitc[a] + 1;
            if (waitc[a] > waitmax) waitmax = waitc[a];
        end
        model_step(rq, ev);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic [N*W-1:0] w);
        wts   = w;
        req   = '0;
        endv  = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mgnt = -1;
        mptr = 0;
        waitmax = 0;
        for (int a = 0; a < N; a++) begin
            mcred[a] = effw(a);
            waitc[a] = 0;
        end
        check_vec("R1 reset grant", gnt, '0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=complete");
            finish_run();
        end
    end

    initial begin
        int seq [8] = '{0, 1, 2, 3, 0, 2, 0, 1};
        logic [N-1:0] one;
        @(negedge clk);

        // R9 weights (3,1,2,0): agent3 weight 0, one-cycle accesses
        do_reset({3'd0, 3'd2, 3'd1, 3'd3});
        for (int i = 0; i < 8; i++) begin
            cyc(4'hF, 4'hF);
            one = '0;
            one[seq[i]] = 1'b1;
            if (i == 7) check_vec("R8 round reload grant", gnt, one);
            else if (i == 0) check_vec("R6 first search from 0", gnt, one);
            else check_vec("R7 R9 weighted order", gnt, one);
        end

        // R3 hold: end on other bits is ignored
        do_reset({3'd2, 3'd2, 3'd2, 3'd2});
        cyc(4'b0000, 4'b1111);
        check_vec("R3 end while idle ignored", gnt, 4'b0000);
        cyc(4'b0010, 4'b0000);
        check_vec("R2 grant from idle", gnt, 4'b0010);
        for (int i = 0; i < 3; i++) begin
            cyc(4'b1111, 4'b1101);
            check_vec("R3 grant held", gnt, 4'b0010);
        end
        cyc(4'b0100, 4'b0010);
        check_vec("R4 back-to-back grant", gnt, 4'b0100);
        cyc(4'b0000, 4'b0100);
        check_vec("R5 grant clears", gnt, 4'b0000);
        cyc(4'b0000, 4'b0000);
        check_vec("R5 stays idle", gnt, 4'b0000);

        // Sweep: weight sets with pseudo-random requests and completions
        for (int cfg = 0; cfg < 16; cfg++) begin
            logic [N*W-1:0] w;
            for (int a = 0; a < N; a++) w[a*W +: W] = W'((cfg * (a + 3) + a) % 8);
            do_reset(w);
            for (int t = 0; t < 400; t++) begin
                logic [N-1:0] rq;
                logic [N-1:0] ev;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rq = lfsr[3:0] | lfsr[7:4] | ((cfg % 2 == 1) ? 4'b0001 : 4'b0000);
                ev = lfsr[11:8] & lfsr[15:12];
                if (t % 50 > 45) rq = '0;
                cyc(rq, ev);
                check_vec("R2 R3 R4 R5 R6 R7 R8 model", gnt, exp_vec());
            end
            check_int("R10 starvation bound", waitmax, STARVE_MAX);
        end

        done = 1'b1;
        finish_run();
    end

endmodule